// File: doc/BRIEF.md
# Separable 2-D FIR Transpose Sequencer

This block filters one square image tile that it holds in a two-bank on-chip buffer. A 16-bit input stream loads the tile: four header words come first, then the pixels in raster order. The sequencer then loads its coefficient registers and runs an 8-tap FIR across every row, reading one word per clock. The results go back into the other bank. In one-pass mode the filtered tile then streams out over a valid/ready port. In two-pass mode the first pass stores its results with row and column address fields exchanged, so a second pass over rows of the stored tile filters the original columns. That second pass stores with the fields exchanged again, so the tile returns to raster order before egress.

The controller is a single state machine with these states. HEADER accepts the four header words and moves to LOAD after the fourth. LOAD accepts N×N pixels and moves to SETUP after the last. SETUP lasts six cycles and then enters RUN. RUN issues one buffer read per cycle for N×N cycles and moves to DRAIN. DRAIN lasts eleven cycles while the pipeline empties. After DRAIN the machine enters REARM if this was the first of two passes, or EGRESS otherwise. REARM lasts fourteen cycles and then re-enters RUN. EGRESS streams N×N words and moves to DONE on the last handshake. DONE lasts one cycle and returns to HEADER.

Top module: `sep_fir_seq`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and done is 0.
- R2: Header word 0 bit 0 selects two-pass mode and bit 1 selects tile size (1 means 64×64, 0 means 32×32). Its other bits and header words 1 to 3 are ignored. The pixels follow in raster order. in_ready is 0 from the edge that accepts the last pixel until the cycle after the done pulse.
- R3: Each pass computes y[r][c] = (Σk h[k]·x[r][c−k] + 64) >>> 7 over k = 0..7, with x[r][c−k] = 0 when c−k < 0. h[k] is signed byte k of coef_i (bits 8k+7:8k). Pixels are signed 16-bit values.
- R4: A result above 32767 or below −32768 is clamped to that limit.
- R5: In one-pass mode the output is the row-filtered tile in raster order. out_valid first rises N²+18 clock edges after the edge that accepts the last pixel.
- R6: In two-pass mode the output is the row-filtered then column-filtered tile in raster order. out_valid first rises 2N²+43 edges after the edge that accepts the last pixel, because a 14-cycle re-arm replaces the 6-cycle setup before the second pass.
- R7: Exactly N² words are output. While out_valid is 1 and out_ready is 0, out_valid and out_data hold.
- R8: done is a single-cycle pulse in the cycle after the last output handshake.
- R9: Each filtered word is written back exactly 11 cycles after its buffer read is issued. coef_i is sampled only in the first setup cycle, and later changes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Ingress word valid |
| in_ready | output | 1 | Ingress word accepted when high with in_valid |
| in_data | input | 16 | Header or pixel word |
| coef_i | input | 64 | Eight signed 8-bit coefficients, tap k in byte k |
| out_valid | output | 1 | Egress word valid |
| out_ready | input | 1 | Egress consumer ready |
| out_data | output | 16 | Filtered pixel |
| done | output | 1 | One-cycle pulse after the last egress word |

## Verification
During egress, the buffer read that fetches the next word and a consumer stall can fall in the same cycle. The read must then be withheld and the held word kept on out_data. The bench provokes this by driving out_ready with an alternating pattern and with a pseudo-random pattern while the tile drains. It judges the result by requiring the captured stream to match the model word for word, and by checking that held data does not move across stalled cycles. The done pulse and the reopening of in_ready follow on consecutive cycles, and the bench checks both at their exact cycles.

// File: rtl/sep_fir_pkg.sv
package sep_fir_pkg;

    typedef enum logic [2:0] {
        ST_HEADER,
        ST_LOAD,
        ST_SETUP,
        ST_RUN,
        ST_DRAIN,
        ST_REARM,
        ST_EGRESS,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/tile_buf.sv
module tile_buf #(
    parameter int DW = 16,
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/fir_core.sv
module fir_core #(
    parameter int DW   = 16,
    parameter int CW   = 8,
    parameter int NTAP = 8,
    parameter int AW   = 13,
    parameter int PIPE = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               coef_load,
    input  logic [NTAP*CW-1:0] coef_in,
    input  logic               in_fire,
    input  logic               in_first,
    input  logic [AW-1:0]      in_addr,
    input  logic [DW-1:0]      rd_data,
    output logic               wb_en,
    output logic [AW-1:0]      wb_addr,
    output logic [DW-1:0]      wb_data
);
    localparam int ACCW = DW + CW + $clog2(NTAP);
    localparam int PW   = DW + CW;
    localparam int DLY  = PIPE - 2;
    localparam logic signed [ACCW-1:0] PMAX = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACCW-1:0] NMIN = ~PMAX;
    localparam logic signed [ACCW-1:0] RND  = ACCW'(1 << (CW - 2));

    logic [NTAP*CW-1:0]      coef_q;
    logic signed [CW-1:0]    coef_w [NTAP];
    logic signed [DW-1:0]    tap [NTAP];
    logic                    rdv, rfirst, tv;
    logic [AW-1:0]           raddr_q, taddr;
    logic signed [ACCW-1:0]  acc, shifted;
    logic [DW-1:0]           y;
    logic                    dv [DLY];
    logic [AW-1:0]           da [DLY];
    logic [DW-1:0]           dd [DLY];

    for (genvar k = 0; k < NTAP; k++) begin : g_coef
        assign coef_w[k] = coef_q[k*CW +: CW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coef_q <= '0;
            rdv    <= 1'b0;
            tv     <= 1'b0;
        end else begin
            if (coef_load) coef_q <= coef_in;
            rdv <= in_fire;
            tv  <= rdv;
        end
    end

    always_ff @(posedge clk) begin
        rfirst  <= in_first;
        raddr_q <= in_addr;
        taddr   <= raddr_q;
        if (rdv) begin
            tap[0] <= rd_data;
            for (int k = 1; k < NTAP; k++) tap[k] <= rfirst ? '0 : tap[k-1];
        end
    end

    always_comb begin
        logic signed [PW-1:0] prod;
        acc = '0;
        for (int k = 0; k < NTAP; k++) begin
            prod = coef_w[k] * tap[k];
            acc  = acc + ACCW'(prod);
        end
        shifted = (acc + RND) >>> (CW - 1);
        if (shifted > PMAX)      y = PMAX[DW-1:0];
        else if (shifted < NMIN) y = NMIN[DW-1:0];
        else                     y = shifted[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DLY; i++) dv[i] <= 1'b0;
        end else begin
            dv[0] <= tv;
            for (int i = 1; i < DLY; i++) dv[i] <= dv[i-1];
        end
    end

    always_ff @(posedge clk) begin
        da[0] <= taddr;
        dd[0] <= y;
        for (int i = 1; i < DLY; i++) begin
            da[i] <= da[i-1];
            dd[i] <= dd[i-1];
        end
    end

    assign wb_en   = dv[DLY-1];
    assign wb_addr = da[DLY-1];
    assign wb_data = dd[DLY-1];

endmodule

// File: rtl/sep_fir_seq.sv
module sep_fir_seq
    import sep_fir_pkg::*;
#(
    parameter int DW        = 16,
    parameter int CW        = 8,
    parameter int NTAP      = 8,
    parameter int LG        = 6,
    parameter int PIPE      = 11,
    parameter int SETUP_CYC = 6,
    parameter int REARM_CYC = 14,
    parameter int HDR_WORDS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DW-1:0]      in_data,
    input  logic [NTAP*CW-1:0] coef_i,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DW-1:0]      out_data,
    output logic               done
);
    localparam int NMAX    = 1 << LG;
    localparam int AW      = 2 * LG + 1;
    localparam int CNT_A   = (SETUP_CYC > REARM_CYC) ? SETUP_CYC : REARM_CYC;
    localparam int CNT_B   = (PIPE > HDR_WORDS) ? PIPE : HDR_WORDS;
    localparam int CNT_TOP = (CNT_A > CNT_B) ? CNT_A : CNT_B;
    localparam int CNTW    = $clog2(CNT_TOP + 1);

    seq_state_e      state, nxt;
    logic [CNTW-1:0] cnt;
    logic [LG-1:0]   row, col, n_last;
    logic            two_pass, big, pass_idx, cur_bank, eg_all;
    logic            in_fire, at_last, rd_fire, eg_rd, coef_load;
    logic            wb_en;
    logic [AW-1:0]   wb_addr, pix_addr, fwd_addr;
    logic [DW-1:0]   wb_data;

    assign n_last   = big ? LG'(NMAX - 1) : LG'(NMAX / 2 - 1);
    assign at_last  = (row == n_last) && (col == n_last);
    assign in_fire  = in_valid && in_ready;
    assign pix_addr = {cur_bank, row, col};
    assign fwd_addr = two_pass ? {~cur_bank, col, row} : {~cur_bank, row, col};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HEADER;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HEADER: if (in_fire && cnt == CNTW'(HDR_WORDS - 1)) nxt = ST_LOAD;
            ST_LOAD:   if (in_fire && at_last) nxt = ST_SETUP;
            ST_SETUP:  if (cnt == CNTW'(SETUP_CYC - 1)) nxt = ST_RUN;
            ST_RUN:    if (at_last) nxt = ST_DRAIN;
            ST_DRAIN:  if (cnt == CNTW'(PIPE - 1))
                           nxt = (two_pass && !pass_idx) ? ST_REARM : ST_EGRESS;
            ST_REARM:  if (cnt == CNTW'(REARM_CYC - 1)) nxt = ST_RUN;
            ST_EGRESS: if (eg_all && out_valid && out_ready) nxt = ST_DONE;
            ST_DONE:   nxt = ST_HEADER;
            default:   nxt = ST_HEADER;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        rd_fire   = 1'b0;
        eg_rd     = 1'b0;
        coef_load = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_HEADER, ST_LOAD: in_ready = 1'b1;
            ST_SETUP:  coef_load = (cnt == '0);
            ST_RUN:    rd_fire = 1'b1;
            ST_EGRESS: eg_rd = !eg_all && (!out_valid || out_ready);
            ST_DONE:   done = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            row       <= '0;
            col       <= '0;
            two_pass  <= 1'b0;
            big       <= 1'b0;
            pass_idx  <= 1'b0;
            cur_bank  <= 1'b0;
            eg_all    <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            if (state == ST_HEADER && in_fire && cnt == '0) begin
                two_pass <= in_data[0];
                big      <= in_data[1];
            end
            if (state != nxt)                          cnt <= '0;
            else if (state != ST_HEADER || in_fire)    cnt <= cnt + 1'b1;

            if (state != nxt) begin
                row <= '0;
                col <= '0;
            end else if ((state == ST_LOAD && in_fire) || rd_fire || eg_rd) begin
                if (col == n_last) begin
                    col <= '0;
                    row <= row + 1'b1;
                end else begin
                    col <= col + 1'b1;
                end
            end

            if (state != nxt)            eg_all <= 1'b0;
            else if (eg_rd && at_last)   eg_all <= 1'b1;

            if (eg_rd)          out_valid <= 1'b1;
            else if (out_ready) out_valid <= 1'b0;

            if (state == ST_SETUP) pass_idx <= 1'b0;
            if (state == ST_DRAIN && nxt != ST_DRAIN) begin
                cur_bank <= ~cur_bank;
                pass_idx <= 1'b1;
            end
        end
    end

    tile_buf #(.DW(DW), .AW(AW)) u_buf (
        .clk   (clk),
        .we    (wb_en || (state == ST_LOAD && in_fire)),
        .waddr (wb_en ? wb_addr : pix_addr),
        .wdata (wb_en ? wb_data : in_data),
        .re    (rd_fire || eg_rd),
        .raddr (pix_addr),
        .rdata (out_data)
    );

    fir_core #(.DW(DW), .CW(CW), .NTAP(NTAP), .AW(AW), .PIPE(PIPE)) u_fir (
        .clk       (clk),
        .rst_n     (rst_n),
        .coef_load (coef_load),
        .coef_in   (coef_i),
        .in_fire   (rd_fire),
        .in_first  (col == '0),
        .in_addr   (fwd_addr),
        .rd_data   (out_data),
        .wb_en     (wb_en),
        .wb_addr   (wb_addr),
        .wb_data   (wb_data)
    );

endmodule

// File: rtl/sep_fir_seq_chk.sv
module sep_fir_seq_chk #(
    parameter int DW   = 16,
    parameter int PIPE = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          done,
    input logic          rd_fire,
    input logic          wb_en
);
    logic [PIPE-1:0] rd_hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_hist <= '0;
        else        rd_hist <= {rd_hist[PIPE-2:0], rd_fire};
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_wb_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> rd_hist[PIPE-1]);

    p_wb_happens_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hist[PIPE-1] |-> wb_en);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready));

    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

endmodule

bind sep_fir_seq sep_fir_seq_chk #(.DW(DW), .PIPE(PIPE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .done      (done),
    .rd_fire   (rd_fire),
    .wb_en     (wb_en)
);

// File: tb/sep_fir_seq_bench.sv
module sep_fir_seq_bench;
    localparam int MAXN = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic [63:0] coef_i = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;
    logic        done;

    always #10 clk = ~clk;

    sep_fir_seq u_sep_fir_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .coef_i(coef_i), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .done(done)
    );

    // {two_pass, big, coef set[1:0], pattern[1:0], ready mode[1:0]}
    localparam logic [7:0] VEC [6] = '{
        8'b00010100, 8'b10010001, 8'b00101000,
        8'b11000110, 8'b01111100, 8'b10101010
    };

    int     checks = 0, failures = 0;
    longint cyc = 0, last_hs = 0;
    logic [15:0] lf = 16'hACE1;
    int h [8];
    int src [MAXN][MAXN];
    int mid [MAXN][MAXN];
    int expv [MAXN][MAXN];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        if (cyc == 190000) begin
            failures++;
            $display("FAIL R5 watchdog expired got=%0d exp=<190000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
        end
    endtask

    function automatic int coef_of(input int set, input int k);
        case (set)
            0: return (k < 2) ? 64 : 0;
            1: return ((k % 2) ? -1 : 1) * 10 * (k + 1);
            2: return 127;
            default: return (k == 0) ? -128 : ((k == 7) ? 127 : 0);
        endcase
    endfunction

    function automatic int pix_of(input int pat, input int r, input int c);
        logic [31:0] v;
        case (pat)
            0: return (r * 64 + c) * 3 - 6000;
            1: begin
                v = (32'(r) * 32'd1103515245 + 32'(c) * 32'd12345 + 32'd777) * 32'd2654435761;
                return int'($signed(v[31:16]));
            end
            2: if (r % 2 == 0) return (c % 3 == 0) ? 32767 : -32768;
               else            return (c % 3 == 0) ? -32768 : 32767;
            default: return (r == c) ? 20000 : ((c == 5) ? -9000 : 0);
        endcase
    endfunction

    function automatic int rsat(input int acc);
        int t = (acc + 64) >>> 7;
        if (t > 32767)  return 32767;
        if (t < -32768) return -32768;
        return t;
    endfunction

    // stage 0: one pass src->expv; 1: src->mid transposed; 2: mid->expv transposed
    task automatic model_pass(input int n, input int stage);
        for (int r = 0; r < n; r++) begin
            for (int c = 0; c < n; c++) begin
                int acc = 0;
                int y;
                for (int k = 0; k < 8; k++)
                    if (c - k >= 0)
                        acc += h[k] * ((stage == 2) ? mid[r][c-k] : src[r][c-k]);
                y = rsat(acc);
                if (stage == 0)      expv[r][c] = y;
                else if (stage == 1) mid[c][r] = y;
                else                 expv[c][r] = y;
            end
        end
    endtask

    task automatic put_word(input logic [15:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        last_hs = cyc;
    endtask

    task automatic send_tile(input bit tp, input bit big, input int n, input int words);
        put_word({14'h1357, big, tp});
        put_word(16'hFFFF);
        put_word(16'h0F0F);
        put_word(16'h8001);
        for (int i = 0; i < words; i++) put_word(16'(src[i / n][i % n]));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic collect(input int n, input bit tp, input int rm, input bit satv);
        int     idx = 0, bad = 0, bgot = 0, bexp = 0;
        longint lat = -1;
        bit     ir_bad = 0, hold_bad = 0, early_done = 0, scr = 0, prev_stall = 0;
        logic [15:0] prev_d = '0;
        logic   d1, d2, ir1, ir2;
        longint exp_lat = tp ? (2 * n * n + 43) : (n * n + 18);
        while (idx < n * n) begin
            @(negedge clk);
            if (!scr && cyc >= last_hs + 3) begin
                coef_i = ~coef_i;  // R9: late coefficient change must not matter
                scr = 1;
            end
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (rm)
                0: out_ready = 1'b1;
                1: out_ready = cyc[0];
                default: out_ready = lf[0] | lf[3];
            endcase
            if (in_ready) ir_bad = 1;
            if (done) early_done = 1;
            if (prev_stall && (!out_valid || out_data != prev_d)) hold_bad = 1;
            if (out_valid && lat < 0) lat = cyc - last_hs;
            if (out_valid && out_ready) begin
                if (int'($signed(out_data)) != expv[idx / n][idx % n]) begin
                    if (bad == 0) begin
                        bgot = int'($signed(out_data));
                        bexp = expv[idx / n][idx % n];
                    end
                    bad++;
                end
                idx++;
            end
            prev_stall = out_valid && !out_ready;
            prev_d = out_data;
        end
        @(negedge clk);
        d1 = done; ir1 = in_ready;
        out_ready = 1'b0;
        @(negedge clk);
        d2 = done; ir2 = in_ready;
        chk(bad == 0, tp ? "R6 R3" : "R5 R3", "first mismatching pixel", bgot, bexp);
        if (satv) chk(bad == 0, "R4", "clamped pixel mismatch count", bad, 0);
        chk(lat == exp_lat, tp ? "R6 R9" : "R5 R9", "edges to first out_valid", lat, exp_lat);
        chk(!hold_bad, "R7", "held word changed during stall", hold_bad, 0);
        chk(!ir_bad && !ir1 && ir2, "R2", "in_ready low until after done", {ir_bad, ir1, ir2}, 3'b001);
        chk(!early_done && d1 && !d2, "R8", "done pulse placement", {early_done, d1, d2}, 3'b010);
    endtask

    task automatic run_vec(input int v);
        bit tp  = VEC[v][7];
        bit big = VEC[v][6];
        int cs  = int'(VEC[v][5:4]);
        int pat = int'(VEC[v][3:2]);
        int rm  = int'(VEC[v][1:0]);
        int n   = big ? 64 : 32;
        for (int k = 0; k < 8; k++) begin
            h[k] = coef_of(cs, k);
            coef_i[k*8 +: 8] = 8'(h[k]);
        end
        for (int r = 0; r < n; r++)
            for (int c = 0; c < n; c++) src[r][c] = pix_of(pat, r, c);
        if (tp) begin
            model_pass(n, 1);
            model_pass(n, 2);
        end else begin
            model_pass(n, 0);
        end
        send_tile(tp, big, n, n * n);
        collect(n, tp, rm, pat == 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready && !out_valid && !done, "R1", "idle outputs in reset",
            {in_ready, out_valid, done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid && !done, "R1", "idle outputs after reset",
            {in_ready, out_valid, done}, 3'b100);

        for (int v = 0; v < 6; v++) run_vec(v);

        // reset in the middle of a tile load
        put_word(16'h0003);
        for (int i = 0; i < 13; i++) put_word(16'(i));
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid && !done, "R1", "idle outputs after mid-load reset",
            {in_ready, out_valid, done}, 3'b100);
        run_vec(0);

        summary();
        $finish;
    end

endmodule